// File: doc/BRIEF.md
# Posted Write Buffer with Line-Eviction Buffer

This block sits between a processor's data port and a system bus and lets stores retire without waiting for the bus. It has two storage paths. The main path holds ordinary posted stores: uncached bufferable stores, stores to write-through memory and store misses to write-back memory. It has four address slots that share a pool of sixteen data words. A store whose word address follows the newest slot is attached to that slot, so one address can carry a short run of consecutive words. The second path holds one dirty cache line of eight words, loaded in a single cycle when the cache evicts or cleans a line.

Both paths drain to a simple valid/ready bus master port as bursts. Each burst carries an incrementing word address and marks its final beat. The main path drains in arrival order, one burst per slot. The line buffer goes first whenever the bus is between bursts. A read whose word address is still held in either path is stalled. A drain request stops new stores and evictions from entering and pulses a done flag once both paths are empty.

Top module: `cpu_post_wbuf`

## Requirements
- R1: After reset `bus_valid`, `cpu_wr_stall`, `ev_stall`, `cpu_rd_stall` and `drain_done` are all low, and both paths are empty.
- R2: `cpu_wr_kind` codes 0 (uncached bufferable), 1 (write-through) and 2 (write-back miss) are buffered. Code 3 (write-back hit) is absorbed by the cache: it is never stalled and produces no bus traffic.
- R3: A buffered store joins the newest slot when all of these hold: its word address equals that slot's base plus its word count, the slot holds fewer than 8 words, a data word is free, and that slot is not the one now on the bus. Otherwise it opens a new slot. Each slot drains as one burst with one beat per word and `bus_last` on the final beat.
- R4: Main-path bursts leave in the order their slots were opened. Beat k of a burst carries address base+k and the k-th word stored in that slot.
- R5: `cpu_wr_stall` is high for a buffered store exactly when one of these holds: a drain is pending, all 16 data words are in use, or the store cannot join and all 4 slots are in use. A stalled store is not taken.
- R6: `ev_stall` is high when `ev_valid` is high while the line buffer is full or a drain is pending. An accepted line drains as an 8-beat burst at word addresses {line,0} to {line,7}, and beat i carries bits [32i+31:32i] of `ev_line_data`.
- R7: A burst that has started runs to its last beat. Between bursts the line buffer has priority over the main path. `bus_valid` is low for exactly one cycle after every last beat.
- R8: `cpu_rd_stall` is high only when `cpu_rd_valid` is high and the read address lies in [base, base+count) of a held slot, or in the held line.
- R9: `drain_req` sets a pending drain. The cycle after both paths are seen empty with a drain pending, `drain_done` is high for exactly one cycle and the pending state clears.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_data` and `bus_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_valid | input | 1 | Store request |
| cpu_wr_kind | input | 2 | Store memory class (0..3, see R2) |
| cpu_wr_addr | input | AW | Store word address |
| cpu_wr_data | input | DW | Store data |
| cpu_wr_stall | output | 1 | Store not taken this cycle |
| cpu_rd_valid | input | 1 | Load request for hazard check |
| cpu_rd_addr | input | AW | Load word address |
| cpu_rd_stall | output | 1 | Load hits held data and must wait |
| ev_valid | input | 1 | Dirty line offered for write-back |
| ev_line_addr | input | AW-3 | Line address |
| ev_line_data | input | 8*DW | Whole line, word i in bits [DW*i+DW-1:DW*i] |
| ev_stall | output | 1 | Line not taken this cycle |
| drain_req | input | 1 | Request to empty both paths |
| drain_done | output | 1 | One-cycle completion pulse |
| bus_valid | output | 1 | Beat offered on the bus |
| bus_addr | output | AW | Beat word address |
| bus_data | output | DW | Beat data |
| bus_last | output | 1 | Final beat of the burst |
| bus_ready | input | 1 | Bus takes the beat |

## Verification
The properties assume that every input is driven to a known value from the first cycle after reset. They also assume that the bus may hold `bus_ready` low for any number of cycles, so the hold and address-step checks must survive long back-pressure. The stimulus keeps a stalled store or eviction on the inputs until it is taken, as a real processor and cache would. It also mixes long `bus_ready`-low stretches, all four store classes and drain pulses. This drives the buffer to its data-full and slot-full limits while the bus stays under arbitrary back-pressure.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic [1:0] {
        WK_UNCACHED = 2'd0,
        WK_WTHRU    = 2'd1,
        WK_WB_MISS  = 2'd2,
        WK_WB_HIT   = 2'd3
    } wr_kind_e;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_MAIN  = 2'd1,
        XS_EVICT = 2'd2
    } xfer_e;

endpackage

// File: rtl/wbuf_evict.sv
module wbuf_evict #(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           load,
    input  logic [AW-$clog2(LINE_WORDS)-1:0] line_addr,
    input  logic [LINE_WORDS*DW-1:0]       line_data,
    input  logic                           take,
    input  logic [AW-1:0]                  probe_addr,
    output logic                           full,
    output logic                           probe_hit,
    output logic [AW-1:0]                  beat_addr,
    output logic [DW-1:0]                  beat_data,
    output logic                           beat_last
);
    localparam int LB = $clog2(LINE_WORDS);
    localparam int LA = AW - LB;

    typedef struct packed {
        logic [LINE_WORDS-1:0][DW-1:0] words;
        logic [LA-1:0]                 line;
        logic [LB-1:0]                 cnt;
        logic                          full;
    } ev_t;

    ev_t q, d;

    always_comb begin
        d = q;
        if (take) begin
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LB'(LINE_WORDS - 1)) begin
                d.full = 1'b0;
                d.cnt  = '0;
            end
        end
        if (load) begin
            d.words = line_data;
            d.line  = line_addr;
            d.cnt   = '0;
            d.full  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full      = q.full;
    assign beat_addr = {q.line, q.cnt};
    assign beat_data = q.words[q.cnt];
    assign beat_last = (q.cnt == LB'(LINE_WORDS - 1));
    assign probe_hit = q.full && (probe_addr[AW-1:LB] == q.line);

endmodule

// File: rtl/wbuf_hazard.sv
module wbuf_hazard #(
    parameter int AW    = 16,
    parameter int SLOTS = 4,
    parameter int LW    = 4
) (
    input  logic [AW-1:0]                 rd_addr,
    input  logic [SLOTS-1:0][AW-1:0]      base,
    input  logic [SLOTS-1:0][LW-1:0]      len,
    input  logic [$clog2(SLOTS)-1:0]      ahead,
    input  logic [$clog2(SLOTS):0]        acnt,
    output logic                          hit
);
    localparam int SPW = $clog2(SLOTS);

    logic [SLOTS-1:0] slot_hit;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [SPW-1:0] rel;
        logic [AW-1:0]  offs;
        assign rel  = SPW'(i) - ahead;
        assign offs = rd_addr - base[i];
        assign slot_hit[i] = ({1'b0, rel} < acnt) && (offs < AW'(len[i]));
    end

    assign hit = |slot_hit;

endmodule

// File: rtl/cpu_post_wbuf.sv
module cpu_post_wbuf
    import wbuf_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int DWORDS     = 16,
    parameter int SLOTS      = 4,
    parameter int BURST_MAX  = 8,
    parameter int LINE_WORDS = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cpu_wr_valid,
    input  logic [1:0]                       cpu_wr_kind,
    input  logic [AW-1:0]                    cpu_wr_addr,
    input  logic [DW-1:0]                    cpu_wr_data,
    output logic                             cpu_wr_stall,
    input  logic                             cpu_rd_valid,
    input  logic [AW-1:0]                    cpu_rd_addr,
    output logic                             cpu_rd_stall,
    input  logic                             ev_valid,
    input  logic [AW-$clog2(LINE_WORDS)-1:0] ev_line_addr,
    input  logic [LINE_WORDS*DW-1:0]         ev_line_data,
    output logic                             ev_stall,
    input  logic                             drain_req,
    output logic                             drain_done,
    output logic                             bus_valid,
    output logic [AW-1:0]                    bus_addr,
    output logic [DW-1:0]                    bus_data,
    output logic                             bus_last,
    input  logic                             bus_ready
);
    localparam int DPW = $clog2(DWORDS);
    localparam int DCW = DPW + 1;
    localparam int SPW = $clog2(SLOTS);
    localparam int SCW = SPW + 1;
    localparam int LW  = $clog2(BURST_MAX + 1);

    typedef struct packed {
        logic [DWORDS-1:0][DW-1:0] data;
        logic [DPW-1:0]            wp;
        logic [DPW-1:0]            rp;
        logic [DCW-1:0]            dcnt;
        logic [SLOTS-1:0][AW-1:0]  base;
        logic [SLOTS-1:0][LW-1:0]  len;
        logic [SPW-1:0]            ahead;
        logic [SPW-1:0]            atail;
        logic [SCW-1:0]            acnt;
        logic [LW-1:0]             sent;
        xfer_e                     st;
        logic                      pend;
        logic                      done;
    } main_t;

    main_t q, d;

    logic           ev_full, ev_hit, ev_last, ev_load, ev_take, main_hit;
    logic [AW-1:0]  ev_addr;
    logic [DW-1:0]  ev_data;
    logic [SPW-1:0] tail;
    logic [AW-1:0]  tail_end;
    logic           buffered, dfull, can_join, can_new, push, main_beat, xfer;

    wbuf_evict #(.AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS)) u_evict (
        .clk(clk), .rst_n(rst_n), .load(ev_load), .line_addr(ev_line_addr),
        .line_data(ev_line_data), .take(ev_take), .probe_addr(cpu_rd_addr),
        .full(ev_full), .probe_hit(ev_hit), .beat_addr(ev_addr),
        .beat_data(ev_data), .beat_last(ev_last)
    );

    wbuf_hazard #(.AW(AW), .SLOTS(SLOTS), .LW(LW)) u_hazard (
        .rd_addr(cpu_rd_addr), .base(q.base), .len(q.len),
        .ahead(q.ahead), .acnt(q.acnt), .hit(main_hit)
    );

    // Bus presentation: a registered source choice, held for the whole burst
    assign bus_valid = (q.st != XS_IDLE);
    assign bus_addr  = (q.st == XS_EVICT) ? ev_addr : q.base[q.ahead] + AW'(q.sent);
    assign bus_data  = (q.st == XS_EVICT) ? ev_data : q.data[q.rp];
    assign bus_last  = (q.st == XS_EVICT) ? ev_last : ((q.sent + 1'b1) == q.len[q.ahead]);

    assign xfer      = bus_valid && bus_ready;
    assign main_beat = xfer && (q.st == XS_MAIN);
    assign ev_take   = xfer && (q.st == XS_EVICT);

    assign ev_stall     = ev_valid && (ev_full || q.pend);
    assign ev_load      = ev_valid && !ev_stall;
    assign cpu_rd_stall = cpu_rd_valid && (main_hit || ev_hit);
    assign drain_done   = q.done;

    always_comb begin
        tail     = q.atail - 1'b1;
        tail_end = q.base[tail] + AW'(q.len[tail]);
        buffered = cpu_wr_valid && (cpu_wr_kind != WK_WB_HIT);
        dfull    = (q.dcnt == DCW'(DWORDS));
        can_join = (q.acnt != '0)
                && !((q.acnt == SCW'(1)) && (q.st == XS_MAIN))
                && (cpu_wr_addr == tail_end)
                && (q.len[tail] != LW'(BURST_MAX))
                && !dfull;
        can_new  = (q.acnt != SCW'(SLOTS)) && !dfull;
        cpu_wr_stall = buffered && (q.pend || !(can_join || can_new));
        push     = buffered && !cpu_wr_stall;

        d      = q;
        d.done = 1'b0;

        if (main_beat) begin
            d.rp   = q.rp + 1'b1;
            d.sent = q.sent + 1'b1;
            if (bus_last) begin
                d.sent  = '0;
                d.ahead = q.ahead + 1'b1;
            end
        end

        if (push) begin
            d.data[q.wp] = cpu_wr_data;
            d.wp         = q.wp + 1'b1;
            if (can_join) begin
                d.len[tail] = q.len[tail] + 1'b1;
            end else begin
                d.base[q.atail] = cpu_wr_addr;
                d.len[q.atail]  = LW'(1);
                d.atail         = q.atail + 1'b1;
            end
        end

        d.dcnt = q.dcnt + DCW'(push) - DCW'(main_beat);
        d.acnt = q.acnt + SCW'(push && !can_join) - SCW'(main_beat && bus_last);

        unique case (q.st)
            XS_IDLE: begin
                if (ev_full)              d.st = XS_EVICT;
                else if (q.acnt != '0)    d.st = XS_MAIN;
            end
            default: begin
                if (xfer && bus_last)     d.st = XS_IDLE;
            end
        endcase

        if (q.pend && (q.dcnt == '0) && !ev_full) begin
            d.done = 1'b1;
            d.pend = 1'b0;
        end else if (drain_req) begin
            d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
    parameter int AW         = 16,
    parameter int DW         = 32,
    parameter int BURST_MAX  = 8,
    parameter int LINE_WORDS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_wr_valid,
    input logic [1:0]    cpu_wr_kind,
    input logic          cpu_wr_stall,
    input logic          cpu_rd_valid,
    input logic          cpu_rd_stall,
    input logic          drain_done,
    input logic          bus_valid,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_data,
    input logic          bus_last,
    input logic          bus_ready
);
    localparam int MAXB = (BURST_MAX > LINE_WORDS) ? BURST_MAX : LINE_WORDS;
    localparam int BW   = $clog2(MAXB + 1);

    logic [BW-1:0] beats_q;
    logic          mid_q;
    logic [AW-1:0] nxt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_q <= '0;
            mid_q   <= 1'b0;
            nxt_q   <= '0;
        end else if (bus_valid && bus_ready) begin
            beats_q <= bus_last ? '0 : beats_q + 1'b1;
            mid_q   <= !bus_last;
            nxt_q   <= bus_addr + 1'b1;
        end
    end

    initial begin
        a_r3_params_pow2 : assert (LINE_WORDS == (1 << $clog2(LINE_WORDS)));
    end

    a_r10_hold_beat : assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data) && $stable(bus_last));

    a_r7_gap_after_last : assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_ready && bus_last |=> !bus_valid);

    a_r3_addr_step : assert property (@(posedge clk) disable iff (!rst_n)
        mid_q && bus_valid |-> bus_addr == nxt_q);

    a_r3_burst_cap : assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_ready |-> beats_q < BW'(MAXB));

    a_r9_done_pulse : assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |=> !drain_done);

    a_r9_done_idle_bus : assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> !bus_valid);

    a_r2_hit_never_stalls : assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_valid && cpu_wr_kind == 2'd3 |-> !cpu_wr_stall);

    a_r8_stall_needs_read : assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd_stall |-> cpu_rd_valid);

endmodule

bind cpu_post_wbuf wbuf_checker #(
    .AW(AW), .DW(DW), .BURST_MAX(BURST_MAX), .LINE_WORDS(LINE_WORDS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_wr_valid(cpu_wr_valid), .cpu_wr_kind(cpu_wr_kind),
    .cpu_wr_stall(cpu_wr_stall), .cpu_rd_valid(cpu_rd_valid), .cpu_rd_stall(cpu_rd_stall),
    .drain_done(drain_done), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_last(bus_last), .bus_ready(bus_ready)
);

// File: tb/cpu_post_wbuf_tb.sv
module cpu_post_wbuf_tb;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          cpu_wr_valid, cpu_wr_stall, cpu_rd_valid, cpu_rd_stall;
    logic [1:0]    cpu_wr_kind;
    logic [AW-1:0] cpu_wr_addr, cpu_rd_addr, bus_addr;
    logic [DW-1:0] cpu_wr_data, bus_data;
    logic          ev_valid, ev_stall, drain_req, drain_done;
    logic [AW-4:0] ev_line_addr;
    logic [8*DW-1:0] ev_line_data;
    logic          bus_valid, bus_last, bus_ready;

    cpu_post_wbuf u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr_valid(cpu_wr_valid), .cpu_wr_kind(cpu_wr_kind),
        .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data), .cpu_wr_stall(cpu_wr_stall),
        .cpu_rd_valid(cpu_rd_valid), .cpu_rd_addr(cpu_rd_addr), .cpu_rd_stall(cpu_rd_stall),
        .ev_valid(ev_valid), .ev_line_addr(ev_line_addr), .ev_line_data(ev_line_data),
        .ev_stall(ev_stall), .drain_req(drain_req), .drain_done(drain_done),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_last(bus_last), .bus_ready(bus_ready)
    );

    int  vectors = 0;
    int  errors  = 0;
    bit  finished = 0;
    bit  full_stall_seen = 0;
    bit  done_seen = 0;

    // behavioural reference state
    int          m_base[$];
    int          m_len[$];
    logic [31:0] m_data[$];
    bit          m_evf;
    int          m_evline;
    logic [31:0] m_evw[8];
    int          m_evcnt, m_st, m_sent;
    bit          m_pend, m_done;
    bit          p_hold;
    logic [63:0] p_addr, p_data, p_last;

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            m_base.delete(); m_len.delete(); m_data.delete();
            m_evf = 0; m_evline = 0; m_evcnt = 0; m_st = 0; m_sent = 0;
            m_pend = 0; m_done = 0; p_hold = 0;
        end else if (!finished) begin
            int  na, nd, nst;
            bit  buffered, jn, nw, e_wst, e_est, e_rst, e_valid, e_last, xfer, ndone;
            int  e_addr;
            logic [31:0] e_data;
            na = m_base.size();
            nd = m_data.size();
            buffered = cpu_wr_valid && (cpu_wr_kind != 2'd3);
            jn = 0;
            if (na > 0 && !(na == 1 && m_st == 1) && nd < 16 && m_len[na-1] < 8 &&
                int'(cpu_wr_addr) == ((m_base[na-1] + m_len[na-1]) & 16'hFFFF)) jn = 1;
            nw = (na < 4) && (nd < 16);
            e_wst = buffered && (m_pend || !(jn || nw));
            e_est = ev_valid && (m_evf || m_pend);
            e_rst = 0;
            for (int i = 0; i < na; i++)
                if (((int'(cpu_rd_addr) - m_base[i]) & 16'hFFFF) < m_len[i]) e_rst = 1;
            if (m_evf && (int'(cpu_rd_addr) >> 3) == m_evline) e_rst = 1;
            e_rst = e_rst && cpu_rd_valid;
            e_valid = (m_st != 0);
            e_addr = 0; e_data = '0; e_last = 0;
            if (m_st == 1) begin
                e_addr = (m_base[0] + m_sent) & 16'hFFFF;
                e_data = m_data[0];
                e_last = (m_sent == m_len[0] - 1);
            end else if (m_st == 2) begin
                e_addr = m_evline * 8 + m_evcnt;
                e_data = m_evw[m_evcnt];
                e_last = (m_evcnt == 7);
            end

            chk("R7", "bus_valid", 64'(bus_valid), 64'(e_valid));
            if (e_valid) begin
                chk("R4", "bus_addr", 64'(bus_addr), 64'(e_addr));
                chk("R4", "bus_data", 64'(bus_data), 64'(e_data));
                chk("R3", "bus_last", 64'(bus_last), 64'(e_last));
            end
            chk("R5", "cpu_wr_stall", 64'(cpu_wr_stall), 64'(e_wst));
            chk("R6", "ev_stall", 64'(ev_stall), 64'(e_est));
            chk("R8", "cpu_rd_stall", 64'(cpu_rd_stall), 64'(e_rst));
            chk("R9", "drain_done", 64'(drain_done), 64'(m_done));
            if (p_hold) begin
                chk("R10", "held beat", {bus_valid, 15'(bus_addr), bus_data, 16'(bus_last)},
                    {1'b1, 15'(p_addr), 32'(p_data), 16'(p_last)});
            end
            if (cpu_wr_stall && !m_pend && buffered) full_stall_seen = 1;
            if (drain_done) done_seen = 1;

            // advance the reference by one clock
            xfer = e_valid && bus_ready;
            p_hold = e_valid && !bus_ready;
            p_addr = 64'(e_addr); p_data = 64'(e_data); p_last = 64'(e_last);
            if (m_st == 0) nst = m_evf ? 2 : (na > 0 ? 1 : 0);
            else           nst = (xfer && e_last) ? 0 : m_st;
            ndone = 0;
            if (m_pend && nd == 0 && !m_evf) begin ndone = 1; m_pend = 0; end
            else if (drain_req) m_pend = 1;
            if (xfer && m_st == 1) begin
                void'(m_data.pop_front());
                m_sent++;
                if (e_last) begin
                    void'(m_base.pop_front()); void'(m_len.pop_front()); m_sent = 0;
                end
            end
            if (xfer && m_st == 2) begin
                m_evcnt++;
                if (e_last) begin m_evf = 0; m_evcnt = 0; end
            end
            if (buffered && !e_wst) begin
                m_data.push_back(cpu_wr_data);
                if (jn) m_len[m_len.size()-1] = m_len[m_len.size()-1] + 1;
                else begin m_base.push_back(int'(cpu_wr_addr)); m_len.push_back(1); end
            end
            if (ev_valid && !e_est) begin
                m_evf = 1; m_evline = int'(ev_line_addr); m_evcnt = 0;
                for (int i = 0; i < 8; i++) m_evw[i] = ev_line_data[32*i +: 32];
            end
            m_st = nst;
            m_done = ndone;
        end
    end

    int wa = 0;

    task automatic cycle(int p_wr, int p_rdy, int p_ev, int p_rd, int p_dr, bit hits);
        @(posedge clk);
        #1;
        if (!(cpu_wr_valid && cpu_wr_stall)) begin
            cpu_wr_valid = ($urandom % 100) < p_wr;
            if (($urandom % 4) != 0) wa = (wa + 1) & 16'hFFFF;
            else                     wa = $urandom % 64;
            cpu_wr_addr = 16'(wa);
            cpu_wr_data = $urandom;
            cpu_wr_kind = hits ? 2'($urandom % 4) : 2'($urandom % 3);
        end
        if (!(ev_valid && ev_stall)) begin
            ev_valid = ($urandom % 100) < p_ev;
            ev_line_addr = 13'($urandom % 8);
            for (int i = 0; i < 8; i++) ev_line_data[32*i +: 32] = $urandom;
        end
        bus_ready    = ($urandom % 100) < p_rdy;
        cpu_rd_valid = ($urandom % 100) < p_rd;
        cpu_rd_addr  = 16'($urandom % 64);
        drain_req    = ($urandom % 100) < p_dr;
    endtask

    initial begin
        rst_n = 0; cpu_wr_valid = 0; cpu_wr_kind = 0; cpu_wr_addr = 0; cpu_wr_data = 0;
        cpu_rd_valid = 0; cpu_rd_addr = 0; ev_valid = 0; ev_line_addr = 0; ev_line_data = '0;
        drain_req = 0; bus_ready = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #2;
        chk("R1", "reset outputs", {59'd0, bus_valid, cpu_wr_stall, ev_stall, cpu_rd_stall, drain_done}, 64'd0);

        // R2: write-back hits never reach the bus
        for (int c = 0; c < 12; c++) begin
            @(posedge clk); #1;
            bus_ready = 1; cpu_wr_valid = 1; cpu_wr_kind = 2'd3;
            cpu_wr_addr = 16'(c); cpu_wr_data = $urandom;
        end
        @(posedge clk); #1 cpu_wr_valid = 0;
        repeat (3) begin
            @(negedge clk); #2;
            chk("R2", "bus_valid after hit stores", 64'(bus_valid), 64'd0);
        end

        for (int c = 0; c < 800; c++) cycle(60, 90, 0, 30, 0, 0);
        for (int c = 0; c < 800; c++) cycle(85, 15, 10, 40, 0, 0);
        for (int c = 0; c < 800; c++) cycle(50, 60, 20, 60, 0, 1);
        for (int c = 0; c < 800; c++) cycle(50, 70, 10, 50, 3, 1);
        for (int c = 0; c < 800; c++) cycle(90, 40, 15, 50, 2, 1);

        // final drain with everything quiet
        @(posedge clk); #1;
        cpu_wr_valid = 0; ev_valid = 0; cpu_rd_valid = 0; bus_ready = 1; drain_req = 1;
        @(posedge clk); #1 drain_req = 0;
        done_seen = 0;
        repeat (60) @(posedge clk);
        chk("R9", "drain completed", 64'(done_seen), 64'd1);
        chk("R5", "full-buffer stall observed", 64'(full_stall_seen), 64'd1);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R9 watchdog got running exp finished");
            finished = 1;
            summary();
            $finish;
        end
    end

endmodule